// File: doc/BRIEF.md
# Free-Running Microsecond Timer with Interval Interrupts

This block holds a 12-bit up-counter that advances by one on every cycle in which an external prescaler raises `tick_en`, nominally once per microsecond. The counter never stops and wraps from all ones back to zero. Two interrupt pulses come from that one counter. `irq_fast` marks every 128 ticks (128 µs) and `irq_slow` marks every 1024 ticks (1.024 ms). Each pulse is raised when the chosen counter bit goes from one to zero.

Firmware reads the count through one byte-wide read port. Selector value 0 returns the low eight count bits. Selector value 1 returns the top four bits, with the upper half of the byte at zero. The two bytes must form a matching pair even when the count carries between the two reads. For this, reading the low byte takes a snapshot of the top four bits, and the next upper read returns that snapshot.

Each interval tap is a two-state machine that follows its counter bit. In state TAP_LOW it moves to TAP_HIGH when the bit is one. In state TAP_HIGH it moves back to TAP_LOW when the bit is zero, and in that cycle it raises its pulse. The read port is a two-state machine. In state RD_LIVE an upper read returns the live top bits. A low-byte read moves it to RD_SNAP, or keeps it there. In RD_SNAP an upper read returns the snapshot and moves it back to RD_LIVE.

Top module: `frt_timer`

## Requirements
- R1: After reset the count is zero, both interrupt outputs are low and `rd_data` is 0x00.
- R2: At each rising clock edge with `tick_en` high the count increases by one. With `tick_en` low the count stays unchanged.
- R3: After 0xFFF the next tick makes the count 0x000.
- R4: `irq_fast` is high for exactly one cycle. That cycle is the one after the tick edge that moves count bit 6 from 1 to 0, which happens once every 128 ticks.
- R5: `irq_slow` is high for exactly one cycle. That cycle is the one after the tick edge that moves count bit 9 from 1 to 0, which happens once every 1024 ticks. Whenever `irq_slow` is high, `irq_fast` is high too.
- R6: No pulse appears on the first tick after reset, even if reset arrived while bit 6 or bit 9 was set.
- R7: A read with `rd_en` high and `rd_sel`=0 puts count bits [7:0] onto `rd_data` after that edge. These are the bits as they stood before any tick at the same edge.
- R8: A read with `rd_sel`=1 and no snapshot pending returns the current count bits [11:8] in `rd_data[3:0]`, with `rd_data[7:4]` zero.
- R9: A low-byte read captures count bits [11:8]. The next upper read returns the captured value even if the count has since carried, and that read clears the snapshot.
- R10: While `rd_en` is low, `rd_data` keeps its value.
- R11: A second low-byte read before an upper read replaces the snapshot with the top bits at that later read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle count enable from the prescaler |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 selects the low byte, 1 selects the upper nibble |
| irq_fast | output | 1 | Pulse every 128 ticks |
| irq_slow | output | 1 | Pulse every 1024 ticks |
| rd_data | output | 8 | Registered read data |

## Verification
The hardest case to reach is a carry into bit 8 that lands between a low-byte read and the upper read that follows it, because only then do the snapshot and live values differ. The bench ticks the counter to 0x0FF, reads the low byte, ticks once into 0x100 and then reads the upper nibble. It reads the nibble again to show the snapshot was released. A reset while bits 6 and 9 are set is reached the same way: the bench parks the count at 0x3C0 before pulling reset.

// File: rtl/frt_pkg.sv
package frt_pkg;

    // Read-port state: live upper bits or a snapshot taken at a low-byte read
    typedef enum logic {
        RD_LIVE = 1'b0,
        RD_SNAP = 1'b1
    } rd_state_e;

    // Interval tap state: level of the followed counter bit
    typedef enum logic {
        TAP_LOW  = 1'b0,
        TAP_HIGH = 1'b1
    } tap_state_e;

    // Read selector encoding
    localparam logic SEL_LO = 1'b0;
    localparam logic SEL_HI = 1'b1;

endpackage

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Natural wrap: all ones plus one is zero in CNT_W bits
    always_comb begin
        cnt_d = cnt_q;
        if (tick_en) begin
            cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/frt_tap_detect.sv
module frt_tap_detect
    import frt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    output logic pulse_o
);

    tap_state_e state_q;
    tap_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TAP_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TAP_LOW:  if (bit_i)  state_d = TAP_HIGH;
            TAP_HIGH: if (!bit_i) state_d = TAP_LOW;
            default:  state_d = TAP_LOW;
        endcase
    end

    // Output: a one-to-zero move of the followed bit
    always_comb begin
        pulse_o = 1'b0;
        unique case (state_q)
            TAP_LOW:  pulse_o = 1'b0;
            TAP_HIGH: pulse_o = !bit_i;
            default:  pulse_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/frt_read_port.sv
module frt_read_port
    import frt_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned LO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             rd_sel,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [LO_W-1:0]  rd_data_o
);

    localparam int unsigned HI_W  = CNT_W - LO_W;
    localparam int unsigned PAD_W = LO_W - HI_W;

    rd_state_e         state_q;
    rd_state_e         state_d;
    logic [HI_W-1:0]   snap_q;
    logic [HI_W-1:0]   snap_d;
    logic [LO_W-1:0]   data_q;
    logic [LO_W-1:0]   data_d;

    logic              rd_lo;
    logic              rd_hi;

    assign rd_lo = rd_en && (rd_sel == SEL_LO);
    assign rd_hi = rd_en && (rd_sel == SEL_HI);

    // State register with snapshot and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_LIVE;
            snap_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            snap_q  <= snap_d;
            data_q  <= data_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_LIVE: if (rd_lo) state_d = RD_SNAP;
            RD_SNAP: if (rd_hi) state_d = RD_LIVE;
            default: state_d = RD_LIVE;
        endcase
    end

    // Outputs: snapshot capture and read-data selection
    always_comb begin
        snap_d = snap_q;
        data_d = data_q;
        if (rd_lo) begin
            snap_d = cnt_i[CNT_W-1:LO_W];
            data_d = cnt_i[LO_W-1:0];
        end else if (rd_hi) begin
            unique case (state_q)
                RD_LIVE: data_d = {{PAD_W{1'b0}}, cnt_i[CNT_W-1:LO_W]};
                RD_SNAP: data_d = {{PAD_W{1'b0}}, snap_q};
                default: data_d = '0;
            endcase
        end
    end

    assign rd_data_o = data_q;

endmodule

// File: rtl/frt_timer.sv
module frt_timer #(
    parameter int unsigned CNT_W    = 12,
    parameter int unsigned LO_W     = 8,
    parameter int unsigned FAST_BIT = 6,
    parameter int unsigned SLOW_BIT = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            rd_en,
    input  logic            rd_sel,
    output logic            irq_fast,
    output logic            irq_slow,
    output logic [LO_W-1:0] rd_data
);

    localparam int unsigned NUM_TAPS = 2;
    localparam int unsigned TAP_BIT [NUM_TAPS] = '{FAST_BIT, SLOW_BIT};

    logic [CNT_W-1:0]    cnt_w;
    logic [NUM_TAPS-1:0] tap_pulse;

    frt_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_o   (cnt_w)
    );

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        frt_tap_detect u_tap (
            .clk     (clk),
            .rst_n   (rst_n),
            .bit_i   (cnt_w[TAP_BIT[g]]),
            .pulse_o (tap_pulse[g])
        );
    end

    frt_read_port #(
        .CNT_W (CNT_W),
        .LO_W  (LO_W)
    ) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel),
        .cnt_i     (cnt_w),
        .rd_data_o (rd_data)
    );

    assign irq_fast = tap_pulse[0];
    assign irq_slow = tap_pulse[1];

endmodule

// File: rtl/frt_timer_chk.sv
module frt_timer_chk #(
    parameter int unsigned CNT_W    = 12,
    parameter int unsigned LO_W     = 8,
    parameter int unsigned FAST_BIT = 6,
    parameter int unsigned SLOW_BIT = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick_en,
    input logic            rd_en,
    input logic            rd_sel,
    input logic [CNT_W-1:0] cnt,
    input logic            irq_fast,
    input logic            irq_slow,
    input logic [LO_W-1:0] rd_data
);

    localparam int unsigned HI_W = CNT_W - LO_W;

    // R2: no tick, no movement
    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt));

    // R4: fast pulse lasts one cycle and sits on a 128 boundary
    p_fast_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |=> !irq_fast);
    p_fast_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> (cnt[FAST_BIT:0] == '0));

    // R5: slow pulse lasts one cycle, sits on a 1024 boundary, coincides with fast
    p_slow_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_slow |=> !irq_slow);
    p_slow_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_slow |-> (cnt[SLOW_BIT:0] == '0));
    p_slow_with_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_slow |-> irq_fast);

    // R8: upper read leaves the top half of the byte at zero
    p_upper_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel) |=> (rd_data[LO_W-1:HI_W] == '0));

    // R10: idle read port holds its data
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind frt_timer frt_timer_chk #(
    .CNT_W    (CNT_W),
    .LO_W     (LO_W),
    .FAST_BIT (FAST_BIT),
    .SLOW_BIT (SLOW_BIT)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .cnt      (cnt_w),
    .irq_fast (irq_fast),
    .irq_slow (irq_slow),
    .rd_data  (rd_data)
);

// File: tb/frt_timer_tb_top.sv
module frt_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic       irq_fast;
    logic       irq_slow;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model
    logic [11:0] m_cnt = '0;
    logic [3:0]  m_snap = '0;
    bit          m_snap_v = 1'b0;
    logic [7:0]  m_rd = '0;
    bit          m_first = 1'b0;
    int          n_fast = 0;
    int          n_slow = 0;

    always #2.5 clk = ~clk;

    frt_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel),
        .irq_fast (irq_fast),
        .irq_slow (irq_slow),
        .rd_data  (rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One clock: drive after a falling edge, sample at the next falling edge
    task automatic step(input bit t, input bit re, input bit sel);
        logic [11:0] pre;
        logic [11:0] post;
        bit ef;
        bit es;
        tick_en = t; rd_en = re; rd_sel = sel;
        pre = m_cnt;
        post = t ? pre + 12'd1 : pre;
        if (re) begin
            if (!sel) begin
                m_rd = pre[7:0];
                m_snap = pre[11:8];
                m_snap_v = 1'b1;
            end else begin
                m_rd = {4'h0, m_snap_v ? m_snap : pre[11:8]};
                m_snap_v = 1'b0;
            end
        end
        ef = t && pre[6] && !post[6] && !m_first;
        es = t && pre[9] && !post[9] && !m_first;
        m_first = 1'b0;
        m_cnt = post;
        @(negedge clk);
        check(irq_fast == ef, "R4/R6 irq_fast", int'(irq_fast), int'(ef));
        check(irq_slow == es, "R5/R6 irq_slow", int'(irq_slow), int'(es));
        check(rd_data == m_rd, "R7/R8/R9/R10 rd_data", int'(rd_data), int'(m_rd));
        if (irq_fast) n_fast++;
        if (irq_slow) n_slow++;
        tick_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
    endtask

    task automatic read_lo(input logic [7:0] exp, input string req);
        step(1'b0, 1'b1, 1'b0);
        check(rd_data == exp, req, int'(rd_data), int'(exp));
    endtask

    task automatic read_hi(input logic [7:0] exp, input string req);
        step(1'b0, 1'b1, 1'b1);
        check(rd_data == exp, req, int'(rd_data), int'(exp));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = '0; m_snap_v = 1'b0; m_rd = '0; m_first = 1'b1;
        @(negedge clk);
    endtask

    // R1
    task automatic t_reset();
        do_reset();
        check(irq_fast == 1'b0, "R1 irq_fast", int'(irq_fast), 0);
        check(irq_slow == 1'b0, "R1 irq_slow", int'(irq_slow), 0);
        check(rd_data == 8'h00, "R1 rd_data", int'(rd_data), 0);
        read_lo(8'h00, "R1 low byte");
        read_hi(8'h00, "R1 upper nibble");
    endtask

    // R2, R6, R10
    task automatic t_count_and_hold();
        ticks(1);
        read_lo(8'h01, "R2 one tick");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0);
        check(rd_data == 8'h01, "R10 held data", int'(rd_data), 1);
        read_lo(8'h01, "R2 no tick no change");
        ticks(9);
        read_lo(8'h0A, "R2 ten ticks");
    endtask

    // R7: read and tick at the same edge
    task automatic t_read_with_tick();
        step(1'b1, 1'b1, 1'b0);
        check(rd_data == 8'h0A, "R7 pre-tick value", int'(rd_data), 8'h0A);
        read_lo(8'h0B, "R7 after tick");
    endtask

    // R9, R8: carry between low and upper reads
    task automatic t_coherence();
        ticks(int'(12'h0FF - m_cnt));
        read_lo(8'hFF, "R9 low at 0x0FF");
        ticks(1);
        read_hi(8'h00, "R9 snapshot upper");
        read_hi(8'h01, "R8 live upper after release");
    endtask

    // R11: second low read refreshes snapshot
    task automatic t_refresh();
        read_lo(8'h00, "R11 first low");
        ticks(256);
        read_lo(8'h00, "R11 second low");
        ticks(256);
        read_hi(8'h02, "R11 refreshed snapshot");
    endtask

    // R4, R5, R3: full period
    task automatic t_full_period();
        n_fast = 0; n_slow = 0;
        ticks(4096);
        check(n_fast == 32, "R4 fast pulses per 4096", n_fast, 32);
        check(n_slow == 4, "R5 slow pulses per 4096", n_slow, 4);
        ticks(int'(12'hFFF - m_cnt));
        read_lo(8'hFF, "R3 low at max");
        read_hi(8'h0F, "R3 upper at max");
        ticks(1);
        read_lo(8'h00, "R3 low after wrap");
        read_hi(8'h00, "R3 upper after wrap");
    endtask

    // R6: reset while bits 6 and 9 are set
    task automatic t_reset_mid();
        ticks(int'(12'h3C0 - m_cnt));
        read_lo(8'hC0, "R6 parked low");
        do_reset();
        ticks(1);
        check(irq_fast == 1'b0 && irq_slow == 1'b0, "R6 no pulse after reset",
              int'({irq_slow, irq_fast}), 0);
        ticks(126);
        n_fast = 0;
        ticks(1);
        check(n_fast == 1, "R4 first pulse at 128", n_fast, 1);
    endtask

    initial begin
        t_reset();
        t_count_and_hold();
        t_read_with_tick();
        t_coherence();
        t_refresh();
        t_full_period();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule